// File: doc/BRIEF.md
# Slow-Idle Clock Gating Controller

This block decides when a processor core and its derived peripheral clocks get to advance while the processor is parked in a low-power idle state. A one-cycle idle request moves it out of normal running. If the request carries a slow flag, the block enters a reduced-rate idle. Otherwise it enters a standard idle. In standard idle the core enable is held low while the peripheral enable stays at full rate. In reduced-rate idle both enables give a single-cycle pulse once every n full-rate cycles. The ratio n is picked by a two-bit selector and is captured when idle is entered.

An enabled interrupt (a request bit whose enable bit is set) ends either idle state. Standard idle reacts on the next cycle. Reduced-rate idle looks at interrupts only on its enable pulses, so the wake latency is bounded by n. Each wake produces a one-cycle wake pulse. It also raises a level that tells the sequencer to resume at the instruction after the idle instruction once the interrupt has been serviced. Cycle-steal requests from DMA engines are granted on the next cycle in every state and never disturb idle.

Top module: `slow_idle_gate`

## Requirements
- R1: After synchronous reset: core_en=1, periph_en=1, idle_flag=0, wake_pulse=0, steal_grant=0, resume_next=0.
- R2: While running, idle_req=1 with slow_sel=0 enters standard idle on the next cycle: idle_flag=1, core_en=0, periph_en=1.
- R3: A request bit whose enable bit is 0 never ends idle, and idle_req seen while already idle has no effect (standard idle keeps periph_en at 1).
- R4: In standard idle, an enabled interrupt present in a cycle gives wake_pulse=1 and idle_flag=0 in the next cycle.
- R5: idle_req=1 with slow_sel=1 enters reduced-rate idle with n set by div_sel (00=16, 01=32, 10=64, 11=128). Counting the first idle cycle as cycle 0, core_en and periph_en are both 1 exactly in cycles k where k mod n = n-1, and 0 otherwise.
- R6: In reduced-rate idle, interrupts are sampled only in enable cycles. The wake pulse appears in the cycle after the first enable cycle at or after the interrupt, so it comes at most n cycles after the interrupt.
- R7: wake_pulse is high for exactly one cycle per wake, and it never occurs without a wake condition.
- R8: steal_req=1 in a cycle gives steal_grant=1 in the next cycle in any state, and idle_flag is unchanged by it.
- R9: resume_next rises together with wake_pulse and stays high until the next idle entry, which clears it.
- R10: div_sel is captured at idle entry; changing it during reduced-rate idle does not change the enable period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| idle_req | input | 1 | One-cycle request to enter idle |
| slow_sel | input | 1 | 1 selects reduced-rate idle, 0 standard idle |
| div_sel | input | 2 | Ratio code: 00=16, 01=32, 10=64, 11=128 |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Per-line interrupt enable (1 = enabled) |
| steal_req | input | 1 | DMA / autobuffer cycle-steal request |
| core_en | output | 1 | Clock enable for the core |
| periph_en | output | 1 | Clock enable for derived peripheral clocks |
| idle_flag | output | 1 | High while in either idle state |
| wake_pulse | output | 1 | One-cycle pulse on leaving idle |
| steal_grant | output | 1 | Cycle-steal grant, one cycle after request |
| resume_next | output | 1 | Resume after the idle instruction once serviced |

## Verification
A divider counter that starts from the wrong value, or that wraps at the wrong terminal, shows up in the first reduced-rate period. The first enable pulse then lands away from cycle n-1, and the wake that follows an interrupt lands in the wrong cycle. A wrongly latched ratio or a state that leaves idle too early shows at the ports within one enable period, as a premature idle_flag drop or an unexpected wake pulse. A bad interrupt qualifier shows either as a wake during masked requests or as no wake within n cycles of an enabled one.

// File: rtl/slow_idle_pkg.sv
package slow_idle_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STD  = 2'd1,
    ST_SLOW = 2'd2
  } idle_state_t;

  // smallest ratio is 2**SI_BASE_LOG, each code step doubles it
  localparam int SI_BASE_LOG = 4;
  localparam int SI_SEL_W    = 2;
  localparam int SI_CNT_W    = SI_BASE_LOG + (1 << SI_SEL_W) - 1;

  function automatic int unsigned ratio_log2(input logic [SI_SEL_W-1:0] sel);
    return SI_BASE_LOG + int'(sel);
  endfunction

  function automatic logic [SI_CNT_W-1:0] ratio_last(input logic [SI_SEL_W-1:0] sel);
    return SI_CNT_W'((1 << ratio_log2(sel)) - 1);
  endfunction

endpackage

// File: rtl/slow_idle_divider.sv
module slow_idle_divider
  import slow_idle_pkg::*;
#(
  parameter int CNT_W = SI_CNT_W,
  parameter int SEL_W = SI_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = CNT_W'(ratio_last(SI_SEL_W'(sel)));
  assign tick = count_en && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || !count_en || tick) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

  // R5: the counter never runs past the selected terminal
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> (cnt <= last));

  // R5: enable pulses are isolated single cycles
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/slow_idle_irq_qual.sv
module slow_idle_irq_qual #(
  parameter int NIRQ = 4
) (
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic            pending
);

  logic [NIRQ-1:0] live;

  for (genvar g = 0; g < NIRQ; g++) begin : g_line
    assign live[g] = irq_req[g] & irq_en[g];
  end

  assign pending = |live;

endmodule

// File: rtl/slow_idle_fsm.sv
module slow_idle_fsm
  import slow_idle_pkg::*;
#(
  parameter int SEL_W = SI_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             slow_sel,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             pending,
  input  logic             tick,
  output idle_state_t      state,
  output logic [SEL_W-1:0] div_q,
  output logic             wake_pulse,
  output logic             resume_next
);

  logic wake_now;

  assign wake_now = pending &&
                    ((state == ST_STD) || (state == ST_SLOW && tick));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      div_q       <= '0;
      wake_pulse  <= 1'b0;
      resume_next <= 1'b0;
    end else begin
      wake_pulse <= wake_now;
      unique case (state)
        ST_RUN: begin
          if (idle_req) begin
            state       <= slow_sel ? ST_SLOW : ST_STD;
            div_q       <= div_sel;
            resume_next <= 1'b0;
          end
        end
        ST_STD, ST_SLOW: begin
          if (wake_now) begin
            state       <= ST_RUN;
            resume_next <= 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // R7: a wake pulse never lasts two cycles
  p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R3: without an enabled request idle is kept
  p_masked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN && !pending) |=> (state != ST_RUN && !wake_pulse));

  // R4: standard idle answers in one cycle
  p_std_fast_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STD && pending) |=> (wake_pulse && state == ST_RUN));

  // R6: reduced-rate idle only wakes from an enable cycle
  p_slow_gated_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLOW && !tick) |=> !wake_pulse);

  // R10: captured ratio holds for the whole idle stay
  p_div_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |=> (state == ST_RUN || $stable(div_q)));

  // R9: the resume level is up whenever a wake pulse is seen
  p_resume_with_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> resume_next);

endmodule

// File: rtl/slow_idle_gate.sv
module slow_idle_gate
  import slow_idle_pkg::*;
#(
  parameter int NIRQ  = 4,
  parameter int SEL_W = SI_SEL_W,
  parameter int CNT_W = SI_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             slow_sel,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [NIRQ-1:0]  irq_req,
  input  logic [NIRQ-1:0]  irq_en,
  input  logic             steal_req,
  output logic             core_en,
  output logic             periph_en,
  output logic             idle_flag,
  output logic             wake_pulse,
  output logic             steal_grant,
  output logic             resume_next
);

  idle_state_t      state;
  logic [SEL_W-1:0] div_q;
  logic             pending;
  logic             tick;
  logic             in_slow;

  assign in_slow = (state == ST_SLOW);

  slow_idle_irq_qual #(.NIRQ(NIRQ)) u_qual (
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .pending (pending)
  );

  slow_idle_divider #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (in_slow),
    .sel      (div_q),
    .tick     (tick)
  );

  slow_idle_fsm #(.SEL_W(SEL_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_req    (idle_req),
    .slow_sel    (slow_sel),
    .div_sel     (div_sel),
    .pending     (pending),
    .tick        (tick),
    .state       (state),
    .div_q       (div_q),
    .wake_pulse  (wake_pulse),
    .resume_next (resume_next)
  );

  always_comb begin
    unique case (state)
      ST_STD:  begin core_en = 1'b0; periph_en = 1'b1; end
      ST_SLOW: begin core_en = tick; periph_en = tick; end
      default: begin core_en = 1'b1; periph_en = 1'b1; end
    endcase
  end

  assign idle_flag = (state != ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) steal_grant <= 1'b0;
    else        steal_grant <= steal_req;
  end

  // R8: a cycle steal never pulls the block out of idle
  p_steal_keeps_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_flag && steal_req && !pending) |=> idle_flag);

  // R2: standard idle freezes the core but keeps peripherals running
  p_std_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STD) |-> (!core_en && periph_en));

endmodule

// File: tb/test_slow_idle_gate.sv
module test_slow_idle_gate;

  localparam int NIRQ = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            idle_req = 1'b0;
  logic            slow_sel = 1'b0;
  logic [1:0]      div_sel = 2'b00;
  logic [NIRQ-1:0] irq_req = '0;
  logic [NIRQ-1:0] irq_en = '0;
  logic            steal_req = 1'b0;
  logic            core_en, periph_en, idle_flag, wake_pulse, steal_grant, resume_next;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int c0 = 0;
  int exp_q[$];
  logic prev_wake = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  slow_idle_gate #(.NIRQ(NIRQ)) i_slow_idle_gate (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .slow_sel(slow_sel),
    .div_sel(div_sel), .irq_req(irq_req), .irq_en(irq_en), .steal_req(steal_req),
    .core_en(core_en), .periph_en(periph_en), .idle_flag(idle_flag),
    .wake_pulse(wake_pulse), .steal_grant(steal_grant), .resume_next(resume_next)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: wake pulses are popped against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (wake_pulse) begin
        chk(!prev_wake, "R7 pulse longer than one cycle", 1, 0);
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected wake cycle", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R4/R6 wake cycle", cyc, e);
        end
      end
      prev_wake <= wake_pulse;
    end
  end

  // driver: called at a negedge, returns in idle cycle 0
  task automatic enter_idle(input logic slow, input logic [1:0] sel);
    idle_req = 1'b1;
    slow_sel = slow;
    div_sel  = sel;
    c0 = cyc + 1;
    @(negedge clk);
    idle_req = 1'b0;
  endtask

  task automatic wait_wake();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) begin
      @(negedge clk);
      #1;
    end
    chk(exp_q.size() == 0, "R6 wake never seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(core_en && periph_en, "R1 enables after reset", {core_en, periph_en}, 3);
    chk(!idle_flag && !wake_pulse && !steal_grant && !resume_next, "R1 flags after reset",
        {idle_flag, wake_pulse, steal_grant, resume_next}, 0);

    // R2 standard idle
    enter_idle(1'b0, 2'b00);
    chk(idle_flag && !core_en && periph_en, "R2 standard idle enables",
        {idle_flag, core_en, periph_en}, 5);

    // R8 cycle steal during idle
    steal_req = 1'b1;
    @(negedge clk);
    steal_req = 1'b0;
    chk(steal_grant && idle_flag, "R8 grant while idle", {steal_grant, idle_flag}, 3);

    // R3 masked request and repeated idle request are ignored
    irq_req = 4'b0100;
    irq_en  = 4'b1011;
    idle_req = 1'b1;
    slow_sel = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    slow_sel = 1'b0;
    repeat (20) @(negedge clk);
    chk(idle_flag && periph_en && !core_en, "R3 masked request keeps standard idle",
        {idle_flag, periph_en, core_en}, 6);

    // R4 unmasking wakes in the next cycle
    irq_en = 4'b1111;
    exp_q.push_back(cyc + 1);
    wait_wake();
    chk(!idle_flag, "R4 idle_flag after wake", idle_flag, 0);
    chk(resume_next, "R9 resume_next after wake", resume_next, 1);
    irq_req = '0;
    irq_en  = '0;
    repeat (3) @(negedge clk);
    chk(resume_next, "R9 resume_next holds", resume_next, 1);

    // R5 / R6 / R10 reduced-rate idle for every code
    for (int s = 0; s < 4; s++) begin
      int n, miss;
      n = 16 << s;
      miss = 0;
      enter_idle(1'b1, 2'(s));
      chk(!resume_next && idle_flag, "R9 resume cleared on entry", resume_next, 0);
      if (s == 0) div_sel = 2'b11; // R10: change ignored
      for (int k = 0; k < 2 * n; k++) begin
        logic want;
        want = ((k % n) == n - 1);
        if (core_en !== want || periph_en !== want || idle_flag !== 1'b1) miss++;
        @(negedge clk);
      end
      chk(miss == 0, (s == 0) ? "R10 ratio captured at entry" : "R5 enable period",
          miss, 0);
      irq_req = 4'b0001;
      irq_en  = 4'b0001;
      exp_q.push_back(c0 + 3 * n);
      wait_wake();
      chk(!idle_flag, "R6 left reduced-rate idle", idle_flag, 0);
      irq_req = '0;
      irq_en  = '0;
      @(negedge clk);
    end

    // R6 interrupt in the middle of a period, ratio 32
    enter_idle(1'b1, 2'b01);
    repeat (5) @(negedge clk);
    irq_req = 4'b1000;
    irq_en  = 4'b1000;
    exp_q.push_back(c0 + 32);
    wait_wake();
    chk(core_en && periph_en, "R6 full rate after wake", {core_en, periph_en}, 3);
    irq_req = '0;
    irq_en  = '0;

    // R8 grant while running
    steal_req = 1'b1;
    @(negedge clk);
    steal_req = 1'b0;
    chk(steal_grant && !idle_flag, "R8 grant while running", {steal_grant, idle_flag}, 2);
    @(negedge clk);
    chk(!steal_grant, "R8 grant drops", steal_grant, 0);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule